// File: doc/BRIEF.md
# Self-Calibrating Serial Byte Receiver

This block receives framed bytes from a host over a single serial wire. It has no fixed baud divider. Each transaction starts with the calibration value 55h. The receiver times that value against its own oversampling clock and stores the host's bit period. It then uses the stored period to recover the command byte and any data bytes that follow in the same transaction.

Every word on the line has the same frame. A low start bit comes first, then eight data bits with the least significant bit first, then a high stop bit. The receiver lines up again on the falling edge of every start bit, so small rate errors do not build up from one word to the next. While the receiver holds a period and is waiting for a start bit, it counts the clocks for which the line stays high. If the line stays high for too long, the receiver treats the transaction as over and waits for a new calibration byte.

The receiver reports each accepted word as a one-cycle strobe. With the strobe it gives the byte and a marker that tells calibration words apart from later words. It also reports the period currently in use and a one-cycle framing-error pulse. Command decoding, the transmitter and register storage belong to other blocks.

Top module: `autobaud_rx`

## Requirements
- R1: Reset clears all state. After reset, `rx_valid`, `frame_err`, `rx_is_cal`, `rx_byte` and `bit_period` are 0, and the receiver holds no period.
- R2: While no period is held, a framed 55h sets `bit_period`. The value is the clock count from the start-bit falling edge to the falling edge that begins data bit 7, divided by 8 and rounded down. A later calibration replaces the value. The word is reported with `rx_valid`=1, `rx_is_cal`=1 and `rx_byte`=55h.
- R3: While a period P is held, each word is sampled at P/2 clocks (rounded down) after its start-bit falling edge and then every P clocks. The bits are assembled least significant bit first. The word is reported as a single-cycle `rx_valid` with `rx_is_cal`=0, even when the byte is 55h.
- R4: If the stop bit is sampled low, `frame_err` pulses for one cycle and no word is reported. The receiver then waits for the line to go high and keeps the period it holds.
- R5: A low pulse that is high again at the start-bit sample point is dropped. No word and no error are reported, and the next proper word is received normally.
- R6: While a period is held, a line that stays high for IDLE_LIMIT clocks between words drops the period. The next 55h is then treated as a calibration word (`rx_is_cal`=1). Gaps shorter than IDLE_LIMIT keep the period.
- R7: A calibration measurement whose period is below MIN_PERIOD is rejected. No word is reported, `bit_period` keeps its value, and the receiver stays without a period.
- R8: `rx_valid` and `frame_err` are never high in the same cycle, and neither is high for two cycles in a row.
- R9: `bit_period` changes only in the cycle in which a calibration word is reported. Data words, framing errors and dropped pulses leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input; idles high |
| rx_byte | output | 8 | Last reported byte |
| rx_valid | output | 1 | One-cycle strobe for a reported byte |
| rx_is_cal | output | 1 | The reported byte was a calibration word |
| bit_period | output | CNT_W | Held bit period in clocks |
| frame_err | output | 1 | One-cycle pulse for a low stop bit |

## Verification
Calibration runs at bit times of 16, 24 and 13 clocks. These show that the divide by eight is exact, and the odd rate also checks the rounded-down half-period sample point. A calibration at 2 clocks per bit must be refused, and a proper calibration that follows it shows the receiver never locked to the bad rate. Data bytes 00h, FFh, A3h and 55h separate bit order and sample placement from stuck lines. A 55h sent with a short gap must come out as data, while the same byte after a long idle must come out as calibration, which separates the timeout from the normal hold. A two-clock glitch and a word with a low stop bit check that only real frames are reported and that the period survives both.

// File: rtl/abrx_pkg.sv
package abrx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,   // no period held, waiting for a calibration start edge
        ST_MEAS,   // timing the calibration pattern
        ST_CSTOP,  // waiting to sample the calibration stop bit
        ST_IDLE,   // period held, waiting for a start edge
        ST_RECV,   // sampling a word with the held period
        ST_DRAIN   // waiting for the line to return high
    } abrx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       is_cal;
    } abrx_word_t;

    localparam logic [7:0] CAL_BYTE   = 8'h55;
    // falling edges after the start edge up to the start of data bit 7
    localparam int         CAL_FALLS  = 4;
    localparam int         FRAME_BITS = 10;

    function automatic logic [3:0] next_bit(input logic [3:0] idx);
        return idx + 4'd1;
    endfunction

endpackage

// File: rtl/abrx_sync.sv
module abrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic q,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    assign q    = chain[STAGES-1];
    assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/abrx_idle_timer.sv
module abrx_idle_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] count;

    assign expire = run && (count == TW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || expire) count <= '0;
        else                       count <= count + 1'b1;
    end
endmodule

// File: rtl/abrx_shift.sv
module abrx_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             din,
    output logic [WIDTH-1:0] q
);
    // first bit in ends up at bit 0
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= {din, q[WIDTH-1:1]};
    end
endmodule

// File: rtl/autobaud_rx.sv
module autobaud_rx
    import abrx_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int MIN_PERIOD  = 4,
    parameter int IDLE_LIMIT  = 100000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_line,
    output logic [7:0]       rx_byte,
    output logic             rx_valid,
    output logic             rx_is_cal,
    output logic [CNT_W-1:0] bit_period,
    output logic             frame_err
);
    // counter spans 8 measured bits plus headroom for 9.5 periods
    localparam int CW = CNT_W + 4;

    abrx_state_e      state;
    logic             line_s, fall_s;
    logic [CW-1:0]    cnt, tgt;
    logic [1:0]       nfall;
    logic [3:0]       bitn;
    logic [CNT_W-1:0] cand;
    logic             locked;
    logic             idle_exp;
    logic             hit;
    logic             sh_en;
    logic [7:0]       sh_q;
    logic [CNT_W-1:0] meas_per;
    abrx_word_t       word_q;

    abrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .din (rx_line), .q (line_s), .fall (fall_s)
    );

    abrx_idle_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
        .clk (clk), .rst (rst), .run (state == ST_IDLE && line_s), .expire (idle_exp)
    );

    assign hit      = (cnt == tgt);
    assign meas_per = cnt[CNT_W+2:3];
    assign sh_en    = (state == ST_RECV) && hit && (bitn >= 4'd1) && (bitn <= 4'd8);

    abrx_shift #(.WIDTH(8)) u_shift (
        .clk (clk), .rst (rst), .en (sh_en), .din (line_s), .q (sh_q)
    );

    assign rx_byte   = word_q.data;
    assign rx_is_cal = word_q.is_cal;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_HUNT;
            cnt        <= '0;
            tgt        <= '0;
            nfall      <= '0;
            bitn       <= '0;
            cand       <= '0;
            locked     <= 1'b0;
            bit_period <= '0;
            word_q     <= '0;
            rx_valid   <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
            case (state)
                ST_HUNT: begin
                    if (fall_s) begin
                        cnt   <= CW'(1);
                        nfall <= '0;
                        state <= ST_MEAS;
                    end
                end
                ST_MEAS: begin
                    cnt <= cnt + 1'b1;
                    if (cnt[CW-1]) begin
                        state <= ST_DRAIN;
                    end else if (fall_s) begin
                        if (nfall == 2'(CAL_FALLS - 1)) begin
                            if (meas_per < CNT_W'(MIN_PERIOD)) begin
                                state <= ST_DRAIN;
                            end else begin
                                cand  <= meas_per;
                                tgt   <= cnt + CW'(meas_per) + CW'(meas_per >> 1);
                                state <= ST_CSTOP;
                            end
                        end else begin
                            nfall <= nfall + 1'b1;
                        end
                    end
                end
                ST_CSTOP: begin
                    cnt <= cnt + 1'b1;
                    if (hit) begin
                        if (line_s) begin
                            bit_period    <= cand;
                            locked        <= 1'b1;
                            word_q.data   <= CAL_BYTE;
                            word_q.is_cal <= 1'b1;
                            rx_valid      <= 1'b1;
                            state         <= ST_IDLE;
                        end else begin
                            frame_err <= 1'b1;
                            state     <= ST_DRAIN;
                        end
                    end
                end
                ST_IDLE: begin
                    if (fall_s) begin
                        cnt   <= CW'(1);
                        tgt   <= CW'(bit_period >> 1);
                        bitn  <= '0;
                        state <= ST_RECV;
                    end else if (idle_exp) begin
                        locked <= 1'b0;
                        state  <= ST_HUNT;
                    end
                end
                ST_RECV: begin
                    cnt <= cnt + 1'b1;
                    if (hit) begin
                        tgt  <= tgt + CW'(bit_period);
                        bitn <= next_bit(bitn);
                        if (bitn == 4'd0) begin
                            if (line_s) state <= ST_IDLE;
                        end else if (bitn == 4'(FRAME_BITS - 1)) begin
                            if (line_s) begin
                                word_q.data   <= sh_q;
                                word_q.is_cal <= 1'b0;
                                rx_valid      <= 1'b1;
                                state         <= ST_IDLE;
                            end else begin
                                frame_err <= 1'b1;
                                state     <= ST_DRAIN;
                            end
                        end
                    end
                end
                ST_DRAIN: begin
                    if (line_s) state <= locked ? ST_IDLE : ST_HUNT;
                end
                default: state <= ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/abrx_chk.sv
module abrx_chk #(
    parameter int CNT_W      = 16,
    parameter int MIN_PERIOD = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [7:0]       rx_byte,
    input logic             rx_valid,
    input logic             rx_is_cal,
    input logic [CNT_W-1:0] bit_period,
    input logic             frame_err
);
    // R8
    valid_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !frame_err);

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R4
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    // R9
    period_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_period != $past(bit_period)) |-> (rx_valid && rx_is_cal));

    // R7
    min_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_is_cal) |-> (bit_period >= CNT_W'(MIN_PERIOD)));

    // R2
    cal_value_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_is_cal) |-> (rx_byte == 8'h55));
endmodule

bind autobaud_rx abrx_chk #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_abrx_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_byte    (rx_byte),
    .rx_valid   (rx_valid),
    .rx_is_cal  (rx_is_cal),
    .bit_period (bit_period),
    .frame_err  (frame_err)
);

// File: tb/tb_autobaud_rx.sv
module tb_autobaud_rx;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 12;
    localparam int MIN_P      = 4;
    localparam int IDLE_LIM   = 600;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx_line = 1'b1;
    logic [7:0]       rx_byte;
    logic             rx_valid;
    logic             rx_is_cal;
    logic [CNT_W-1:0] bit_period;
    logic             frame_err;

    int checks = 0;
    int fails = 0;
    int n_valid = 0;
    int n_ferr = 0;
    int n_overlap = 0;
    logic [7:0] last_byte = 8'h00;
    logic       last_cal = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    autobaud_rx #(
        .CNT_W(CNT_W), .MIN_PERIOD(MIN_P), .IDLE_LIMIT(IDLE_LIM), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .rx_is_cal(rx_is_cal), .bit_period(bit_period),
        .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                n_valid++;
                last_byte = rx_byte;
                last_cal  = rx_is_cal;
            end
            if (frame_err) n_ferr++;
            if (rx_valid && frame_err) n_overlap++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input int bt, input bit stop_ok);
        rx_line = 1'b0;
        repeat (bt) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            repeat (bt) @(negedge clk);
        end
        rx_line = stop_ok;
        repeat (bt) @(negedge clk);
        rx_line = 1'b1;
        repeat (3*bt) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1", "rx_valid", int'(rx_valid), 0);
        chk("R1", "frame_err", int'(frame_err), 0);
        chk("R1", "rx_is_cal", int'(rx_is_cal), 0);
        chk("R1", "rx_byte", int'(rx_byte), 0);
        chk("R1", "bit_period", int'(bit_period), 0);
    endtask

    task automatic t_reject_fast;
        int v0 = n_valid;
        send_frame(8'h55, 2, 1'b1);
        chk("R7", "no word for short period", n_valid - v0, 0);
        chk("R7", "period unchanged", int'(bit_period), 0);
    endtask

    task automatic t_cal(input int bt);
        int v0 = n_valid;
        send_frame(8'h55, bt, 1'b1);
        chk("R2", "cal word count", n_valid - v0, 1);
        chk("R2", "cal marker", int'(last_cal), 1);
        chk("R2", "cal byte", int'(last_byte), 8'h55);
        chk("R2", "measured period", int'(bit_period), bt);
    endtask

    task automatic t_data(input logic [7:0] b, input int bt);
        int v0 = n_valid;
        send_frame(b, bt, 1'b1);
        chk("R3", "data word count", n_valid - v0, 1);
        chk("R3", "data byte", int'(last_byte), int'(b));
        chk("R3", "data marker", int'(last_cal), 0);
    endtask

    task automatic t_glitch(input int bt);
        int v0 = n_valid;
        int e0 = n_ferr;
        rx_line = 1'b0;
        repeat (2) @(negedge clk);
        rx_line = 1'b1;
        repeat (3*bt) @(negedge clk);
        chk("R5", "glitch word count", n_valid - v0, 0);
        chk("R5", "glitch error count", n_ferr - e0, 0);
        t_data(8'h3C, bt);
        chk("R9", "period after glitch", int'(bit_period), bt);
    endtask

    task automatic t_frame_err(input int bt);
        int v0 = n_valid;
        int e0 = n_ferr;
        send_frame(8'h96, bt, 1'b0);
        chk("R4", "error pulse count", n_ferr - e0, 1);
        chk("R4", "no word on error", n_valid - v0, 0);
        chk("R9", "period after error", int'(bit_period), bt);
        t_data(8'h5A, bt);
    endtask

    task automatic t_timeout;
        repeat (IDLE_LIM + 100) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_reject_fast();
        t_cal(16);
        t_data(8'hA3, 16);
        t_data(8'h00, 16);
        t_data(8'hFF, 16);
        // R6: a short gap keeps the period, so 55h arrives as data
        t_data(8'h55, 16);
        chk("R9", "period after data", int'(bit_period), 16);
        t_glitch(16);
        t_frame_err(16);
        // R6: a long idle drops the period, so 55h recalibrates
        t_timeout();
        t_cal(24);
        chk("R6", "recalibrated after idle", int'(last_cal), 1);
        t_data(8'hC1, 24);
        t_timeout();
        t_cal(13);
        t_data(8'h7E, 13);
        chk("R8", "valid and error overlap cycles", n_overlap, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule